// File: doc/BRIEF.md
# Match-Based Watchdog Timer

A memory-mapped timer block whose free-running 32-bit up-counter advances once per tick. One tick is one microsecond; it is made by dividing the core clock by a parameter. The block holds a bank of 32-bit compare slots. One of these slots, channel 5 by default, is wired to the watchdog. The other slots only store values. Software keeps the system alive in three steps. It first freezes a copy of the counter through a capture register. It then reads that copy. Finally it writes the copy plus the timeout, in ticks, into the watchdog compare slot. For a timeout given in seconds, the tick count is the seconds multiplied by one million. The supported range is 30 to 600 seconds.

The block fires when the counter steps onto the value held in the watchdog compare slot. Two conditions must also hold: the per-channel interrupt enable bit for that channel is set, and the global arm bit is set. When it fires, the block emits a single-cycle reset request toward the system reset controller and sets a sticky flag that stays set until reset. All arithmetic wraps modulo 2^32. A deadline computed past the top of the counter range therefore fires after the counter rolls over to zero. Software can compute the remaining time as the compare value minus the live counter.

Top module: `wdt_match_timer`

## Requirements
- R1: After reset the counter holds the reset-value parameter (0 by default). All compare slots, the interrupt enable, the arm bit and the captured copy read 0. The reset request and the sticky flag are low.
- R2: The counter, read at offset 0x00, rises by exactly one every CLKS_PER_TICK core clocks and wraps from 0xFFFFFFFF to 0. Writes to it are ignored.
- R3: A write to offset 0x30 with bit 0 set copies the counter into the capture register, read at offset 0x34. A write there with bit 0 clear leaves the copy unchanged. Offset 0x30 always reads 0.
- R4: Compare slot i is read and written as a full 32-bit word at offset 0x08 + 4*i, for i from 0 to NUM_MATCH-1. The watchdog slot, channel 5, sits at 0x1C.
- R5: Offset 0x24 holds one interrupt enable bit per compare channel in bits [NUM_MATCH-1:0], and its upper bits read 0. Offset 0x28 holds the arm bit in bit 0, and its other bits read 0.
- R6: The reset request is high for exactly one core cycle. It rises in the cycle in which the counter first shows the watchdog compare value, provided that interrupt enable bit 5 and the arm bit were both set.
- R7: If either interrupt enable bit 5 or the arm bit is clear, the counter reaching the watchdog compare value produces no reset request.
- R8: Compare channels other than the watchdog channel never cause a reset request, whatever their enable bits hold.
- R9: The sticky flag rises together with the first reset request and stays high until the block is reset.
- R10: A watchdog compare value that was computed past 0xFFFFFFFF, and so wrapped to a small value, fires once the counter rolls over and reaches it.
- R11: Reads of offsets outside the map return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is selected |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| wdt_fired | output | 1 | Sticky flag: the watchdog has fired since reset |

## Verification
The hardest state to reach from the ports is a deadline that wraps past zero. With a zero-based counter, reaching it would take about four billion ticks. The bench therefore builds the block with the counter's reset value set sixteen ticks below the top of the range and with four core clocks per tick. It captures the counter and arms a deadline thirty ticks ahead, which wraps to a small value. It then watches the counter through the bus in every cycle, so that the request edge can be tied to the exact counter value and to a width of one cycle. The gating cases are set up so that the counter runs through a compare value that matches while one enable is missing, or through matching values on the other channels, and no request may appear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MATCH0 = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LATCH  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SNAP   = 8'h34;

  // byte offset of compare slot idx (4-byte stride)
  function automatic logic [ADDR_W-1:0] match_ofs(input int unsigned idx);
    return OFS_MATCH0 + ADDR_W'(idx * 4);
  endfunction

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  wdata;
  } bus_req_t;
endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_pkg::*;
#(
  parameter int unsigned      CLKS_PER_TICK = 50,
  parameter logic [REG_W-1:0] CNT_RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [REG_W-1:0] count
);

  logic [REG_W-1:0] count_q;
  logic [REG_W-1:0] count_d;

  generate
    if (CLKS_PER_TICK <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int unsigned     PRE_W    = $clog2(CLKS_PER_TICK);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] pre_d;

      always_comb begin
        if (pre_q == PRE_LAST) pre_d = '0;
        else                   pre_d = pre_q + PRE_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = (pre_q == PRE_LAST);
    end
  endgenerate

  // counter advances on the last core clock of each tick period
  always_comb count_d = count_q + REG_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= CNT_RESET_VAL;
    else if (tick) count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_MATCH = 6,
  parameter int unsigned WDT_CH    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_req_t         req,
  input  logic [REG_W-1:0] count,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] match_wdt,
  output logic             wdt_chan_en,
  output logic             wdt_arm_en
);

  localparam int unsigned PAD_W = REG_W - NUM_MATCH;

  logic [REG_W-1:0]     match_q [NUM_MATCH];
  logic [NUM_MATCH-1:0] irq_en_q, irq_en_d;
  logic                 arm_q, arm_d;
  logic [REG_W-1:0]     snap_q, snap_d;
  logic                 irq_wr, arm_wr, latch_wr;
  logic [REG_W-1:0]     rd_val;

  assign irq_wr   = req.wr && (req.addr == OFS_IRQ_EN);
  assign arm_wr   = req.wr && (req.addr == OFS_ARM);
  assign latch_wr = req.wr && (req.addr == OFS_LATCH) && req.wdata[0];

  // compare slot bank
  generate
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_slot
      logic             slot_wr;
      logic [REG_W-1:0] slot_d;

      assign slot_wr = req.wr && (req.addr == match_ofs(i));

      always_comb slot_d = req.wdata;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       match_q[i] <= '0;
        else if (slot_wr) match_q[i] <= slot_d;
      end
    end
  endgenerate

  // control and capture next state
  always_comb begin
    irq_en_d = req.wdata[NUM_MATCH-1:0];
    arm_d    = req.wdata[0];
    snap_d   = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_en_q <= '0;
    else if (irq_wr) irq_en_q <= irq_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (arm_wr) arm_q <= arm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (latch_wr) snap_q <= snap_d;
  end

  // read mux
  always_comb begin
    rd_val = '0;
    unique case (req.addr)
      OFS_COUNT:  rd_val = count;
      OFS_IRQ_EN: rd_val = {{PAD_W{1'b0}}, irq_en_q};
      OFS_ARM:    rd_val = {{(REG_W-1){1'b0}}, arm_q};
      OFS_SNAP:   rd_val = snap_q;
      default:    rd_val = '0;
    endcase
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (req.addr == match_ofs(i)) rd_val = match_q[i];
    end
  end

  assign rdata       = req.rd ? rd_val : '0;
  assign match_wdt   = match_q[WDT_CH];
  assign wdt_chan_en = irq_en_q[WDT_CH];
  assign wdt_arm_en  = arm_q;

endmodule

// File: rtl/wdt_trigger.sv
module wdt_trigger
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [REG_W-1:0] count,
  input  logic [REG_W-1:0] match_val,
  input  logic             chan_en,
  input  logic             arm_en,
  output logic             rst_req,
  output logic             fired
);

  logic [REG_W-1:0] count_next;
  logic             hit;
  logic             req_d, fired_d;
  logic             req_q, fired_q;

  // hit is registered on the same edge that moves the counter onto the match
  always_comb begin
    count_next = count + REG_W'(1);
    hit        = tick && chan_en && arm_en && (count_next == match_val);
    req_d      = hit;
    fired_d    = fired_q || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      fired_q <= fired_d;
    end
  end

  assign rst_req = req_q;
  assign fired   = fired_q;

endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
  import wdt_pkg::*;
#(
  parameter int unsigned      CLKS_PER_TICK = 50,
  parameter int unsigned      NUM_MATCH     = 6,
  parameter int unsigned      WDT_CH        = 5,
  parameter logic [REG_W-1:0] CNT_RESET_VAL = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_req,
  output logic        wdt_fired
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             tick;
  logic [REG_W-1:0] cnt_val;
  logic [REG_W-1:0] match_wdt;
  logic             wdt_chan_en;
  logic             wdt_arm_en;
  bus_req_t         req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    req.wr    = bus_sel && bus_wr;
    req.rd    = bus_sel && !bus_wr;
    req.addr  = bus_addr;
    req.wdata = bus_wdata;
  end

  wdt_tick_counter #(
    .CLKS_PER_TICK (CLKS_PER_TICK),
    .CNT_RESET_VAL (CNT_RESET_VAL)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick),
    .count (cnt_val)
  );

  wdt_regs #(
    .NUM_MATCH (NUM_MATCH),
    .WDT_CH    (WDT_CH)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .req         (req),
    .count       (cnt_val),
    .rdata       (bus_rdata),
    .match_wdt   (match_wdt),
    .wdt_chan_en (wdt_chan_en),
    .wdt_arm_en  (wdt_arm_en)
  );

  wdt_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick),
    .count     (cnt_val),
    .match_val (match_wdt),
    .chan_en   (wdt_chan_en),
    .arm_en    (wdt_arm_en),
    .rst_req   (wdt_rst_req),
    .fired     (wdt_fired)
  );

endmodule

// File: rtl/wdt_match_timer_chk.sv
module wdt_match_timer_chk (
  input logic        clk,
  input logic        rst_core_n,
  input logic [31:0] count,
  input logic [31:0] match_wdt,
  input logic        chan_en,
  input logic        arm_en,
  input logic        rst_req,
  input logic        fired
);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (count != $past(count)) |-> (count == $past(count) + 32'd1));

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_req |=> !rst_req);

  p_on_match_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_req |-> (count == $past(match_wdt)));

  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_req |-> $past(chan_en && arm_en));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    fired |=> fired);

  p_fired_cause_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(fired) |-> rst_req);

endmodule

bind wdt_match_timer wdt_match_timer_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .count      (cnt_val),
  .match_wdt  (match_wdt),
  .chan_en    (wdt_chan_en),
  .arm_en     (wdt_arm_en),
  .rst_req    (wdt_rst_req),
  .fired      (wdt_fired)
);

// File: tb/tb_wdt_match_timer.sv
module tb_wdt_match_timer;
  localparam int unsigned TPT    = 4;
  localparam logic [31:0] RV     = 32'hFFFF_FFF0;
  localparam int          NVEC   = 15;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;
  logic        wdt_fired;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  wdt_match_timer #(
    .CLKS_PER_TICK (TPT),
    .NUM_MATCH     (6),
    .WDT_CH        (5),
    .CNT_RESET_VAL (RV)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req),
    .wdt_fired   (wdt_fired)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h08, 32'hA5A5_0001, 32'hA5A5_0001},  // R4
    {8'h0C, 32'h5A5A_0002, 32'h5A5A_0002},  // R4
    {8'h10, 32'h0000_FFFF, 32'h0000_FFFF},  // R4
    {8'h14, 32'hFFFF_0000, 32'hFFFF_0000},  // R4
    {8'h18, 32'h1357_9BDF, 32'h1357_9BDF},  // R4
    {8'h1C, 32'h2468_ACE0, 32'h2468_ACE0},  // R4 watchdog slot
    {8'h24, 32'hFFFF_FFDF, 32'h0000_001F},  // R5
    {8'h28, 32'hFFFF_FFFE, 32'h0000_0000},  // R5
    {8'h28, 32'h0000_0003, 32'h0000_0001},  // R5
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h38, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'hFC, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h30, 32'h0000_0000, 32'h0000_0000}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic capture(output logic [31:0] s);
    bus_write(8'h30, 32'h1);
    bus_read(8'h34, s);
  endtask

  // watch the counter every cycle, count request cycles, record counter at first one
  task automatic watch(input int clocks, output int pulses, output logic [31:0] at);
    pulses = 0; at = '0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
    for (int k = 0; k < clocks; k++) begin
      @(negedge clk);
      #1;
      if (wdt_rst_req) begin
        pulses++;
        if (pulses == 1) at = bus_rdata;
      end
    end
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s, c0, c1, m;
    int p;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R1 reset state
    chk("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
    chk("R1 fired", {31'b0, wdt_fired}, 32'h0);
    bus_read(8'h00, v);
    chk("R1 counter near reset value", {31'b0, (v - RV) <= 32'd2}, 32'h1);
    bus_read(8'h1C, v); chk("R1 match5", v, 32'h0);
    bus_read(8'h08, v); chk("R1 match0", v, 32'h0);
    bus_read(8'h24, v); chk("R1 irq_en", v, 32'h0);
    bus_read(8'h28, v); chk("R1 arm", v, 32'h0);
    bus_read(8'h34, v); chk("R1 snapshot", v, 32'h0);

    // R10 + R6: deadline wraps past zero
    capture(s);
    m = s + 32'd30;
    chk("R10 deadline wrapped", {31'b0, m < s}, 32'h1);
    bus_write(8'h1C, m);
    bus_write(8'h24, 32'h20);
    bus_write(8'h28, 32'h1);
    watch(40 * TPT, p, c0);
    chk("R6 one pulse (R10 wrap)", p, 32'd1);
    chk("R10 fired at wrapped match", c0, m);
    chk("R9 fired set", {31'b0, wdt_fired}, 32'h1);
    repeat (10) @(negedge clk);
    chk("R9 fired sticky", {31'b0, wdt_fired}, 32'h1);

    // R2 rate
    bus_read(8'h00, c0);
    repeat (TPT * 7 - 1) @(negedge clk);
    bus_read(8'h00, c1);
    chk("R2 counter rate", c1, c0 + 32'd7);
    bus_write(8'h00, 32'h0BAD_0000);
    bus_read(8'h00, c1);
    chk("R2 counter not writable", {31'b0, (c1 - c0) < 32'd16}, 32'h1);

    // R3 capture
    capture(s);
    bus_read(8'h00, c0);
    chk("R3 snapshot tracks counter", {31'b0, (c0 - s) <= 32'd1}, 32'h1);
    repeat (5 * TPT) @(negedge clk);
    bus_write(8'h30, 32'hFFFF_FFFE);
    bus_read(8'h34, v);
    chk("R3 bit0 clear no capture", v, s);
    bus_read(8'h30, v);
    chk("R3 latch reads zero", v, 32'h0);

    // R7 arm bit clear
    capture(s);
    bus_write(8'h1C, s + 32'd10);
    bus_write(8'h24, 32'h20);
    bus_write(8'h28, 32'h0);
    watch(15 * TPT, p, c0);
    chk("R7 no pulse when disarmed", p, 32'd0);

    // R7 channel enable clear
    capture(s);
    bus_write(8'h1C, s + 32'd10);
    bus_write(8'h24, 32'h1F);
    bus_write(8'h28, 32'h1);
    watch(15 * TPT, p, c0);
    chk("R7 no pulse when channel enable clear", p, 32'd0);

    // R8 other channels
    capture(s);
    for (int i = 0; i < 5; i++) bus_write(8'h08 + 8'(i * 4), s + 32'd8);
    bus_write(8'h1C, s + 32'd100000);
    bus_write(8'h24, 32'h3F);
    bus_write(8'h28, 32'h1);
    watch(15 * TPT, p, c0);
    chk("R8 other channels silent", p, 32'd0);

    // R6 timing, second firing
    capture(s);
    m = s + 32'd12;
    bus_write(8'h1C, m);
    watch(20 * TPT, p, c0);
    chk("R6 one-cycle pulse", p, 32'd1);
    chk("R6 pulse at match value", c0, m);
    bus_write(8'h28, 32'h0);
    bus_write(8'h24, 32'h0);

    // R4 R5 R11 vector table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      bus_read(VEC[i][71:64], v);
      chk($sformatf("R4/R5/R11 vec %0d", i), v, VEC[i][31:0]);
    end
    // R11 undefined writes left slots intact
    for (int i = 0; i < 6; i++) begin
      bus_read(VEC[i][71:64], v);
      chk("R11 slots intact", v, VEC[i][31:0]);
    end
    bus_write(8'h28, 32'h0);

    // R9 flag clears only by reset; R1 after second reset
    chk("R9 fired before reset", {31'b0, wdt_fired}, 32'h1);
    do_reset();
    chk("R9 fired cleared by reset", {31'b0, wdt_fired}, 32'h0);
    bus_read(8'h1C, v);
    chk("R1 match5 after reset", v, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule